// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of memory segments into the descriptor table read by a bus-master disk DMA engine. Each segment arrives on a valid/ready stream as a 32-bit bus address, a 32-bit byte length and a flag marking the final segment of the request. For each piece of a segment, the block emits one descriptor: an address word followed by a count/control word.

A descriptor never crosses a 64 KB address boundary. In the default format, the low 16 bits of the control word hold the byte count. Some controllers read a count of zero as zero bytes rather than 64 KB, so a full 64 KB piece is sent as two 32 KB descriptors. On success, the final descriptor carries an end-of-table flag in bit 31, and the block reports done together with the descriptor total. The block reports failure in two cases: the table would exceed its configured size, or the request yields no descriptors. The caller then falls back to programmed I/O.

A word-count format can be chosen by parameter. It is meant for engines that move 32-bit aligned data. In this format, bits 31:16 hold (bytes/4)-1, there is no 32 KB split, and no end flag is set. The newest descriptor is held back for one step, so the end flag can be added before that descriptor leaves the block.

Top module: `seg_desc_builder`

## Requirements
- R1: After reset, seg_ready_o, desc_valid_o, done_o and fail_o are all low.
- R2: A descriptor's byte count never exceeds 0x10000 minus the low 16 bits of its address. A segment that crosses a 64 KB boundary is cut at that boundary.
- R3: A segment's descriptors are contiguous. Each starts where the previous one ended, and their byte counts add up to the segment length.
- R4: In the default format, a 64 KB piece is emitted as (A, 0x8000) followed by (A+0x8000, 0x8000). No control word has 0x0000 in its low 16 bits.
- R5: In the default format, bit 31 of the control word is set on the final descriptor of a successful build and on no other descriptor.
- R6: A build that needs more than MAX_ENTRIES descriptors pulses fail_o, never pulses done_o, and emits no more than MAX_ENTRIES descriptors. Both halves of a 64 KB split count toward the limit. A build of exactly MAX_ENTRIES succeeds.
- R7: A build that yields zero descriptors pulses fail_o and does not pulse done_o.
- R8: A segment of length zero is accepted and produces no descriptor. A zero-length segment flagged as last still ends the build.
- R9: With ALT_FMT=1, bits 31:16 of each control word hold (bytes/4)-1 and bits 15:0 are zero. A 64 KB piece stays as a single descriptor, and no end flag is set.
- R10: On success, done_o pulses once, fail_o stays low, and desc_total_o equals the number of descriptors emitted.
- R11: desc_idx_o numbers the emitted descriptors 0, 1, 2, ... in emission order, and that order follows segment order and address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a new build while the block is idle |
| seg_valid_i | input | 1 | A segment is offered |
| seg_addr_i | input | 32 | Segment bus address |
| seg_len_i | input | 32 | Segment length in bytes |
| seg_last_i | input | 1 | Marks the final segment of the request |
| seg_ready_o | output | 1 | Segment accepted when high together with valid |
| desc_valid_o | output | 1 | A descriptor is present this cycle |
| desc_idx_o | output | CNT_W | Position of the descriptor in the table |
| desc_addr_o | output | 32 | Address word of the descriptor |
| desc_ctrl_o | output | 32 | Count/control word of the descriptor |
| done_o | output | 1 | One-cycle pulse: table complete |
| fail_o | output | 1 | One-cycle pulse: overflow or empty table |
| desc_total_o | output | CNT_W | Descriptor count of the last successful build |

## Verification
The bench covers these segment patterns:
- An aligned short segment checks the basic word pair and the end flag.
- A segment straddling 64 KB tells boundary cutting apart from plain pass-through.
- An aligned 64 KB segment separates the 32 KB split from a naive zero count.
- A mix of segments that includes zero-length entries checks ordering and skipping.

The table limit is tested at exactly MAX_ENTRIES descriptors and one split past it, which catches off-by-one errors in the limit check. A second instance built with the word-count format checks the alternate encoding, the absence of both the split and the end flag, and its own small limit.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

  localparam logic [16:0] WINDOW_BYTES = 17'h10000;
  localparam logic [16:0] HALF_BYTES   = 17'h08000;

  // bytes left before the next 64 KB boundary
  function automatic logic [16:0] room_left(input logic [15:0] lo);
    return WINDOW_BYTES - {1'b0, lo};
  endfunction

  // size of the next piece of a segment
  function automatic logic [16:0] pick_chunk(input logic [31:0] addr,
                                             input logic [31:0] rem,
                                             input logic        split_full);
    logic [16:0] room;
    logic [16:0] c;
    room = room_left(addr[15:0]);
    if (rem < {15'b0, room}) c = rem[16:0];
    else                     c = room;
    if (split_full && (c == WINDOW_BYTES)) c = HALF_BYTES;
    return c;
  endfunction

  // byte count in the low half
  function automatic logic [31:0] ctrl_bytes(input logic [16:0] chunk);
    return {16'h0000, chunk[15:0]};
  endfunction

  // (words - 1) in the high half
  function automatic logic [31:0] ctrl_words(input logic [16:0] chunk);
    logic [16:0] w;
    w = {2'b00, chunk[16:2]} - 17'd1;
    return {w[15:0], 16'h0000};
  endfunction

endpackage

// File: rtl/seg_chunker.sv
module seg_chunker
  import seg_desc_pkg::*;
#(
  parameter bit ALT_FMT = 1'b0
) (
  input  logic [31:0] cur_addr,
  input  logic [31:0] cur_rem,
  output logic [16:0] chunk,
  output logic [31:0] ctrl,
  output logic [31:0] nxt_addr,
  output logic [31:0] nxt_rem
);

  generate
    if (ALT_FMT) begin : g_words
      assign chunk = pick_chunk(cur_addr, cur_rem, 1'b0);
      assign ctrl  = ctrl_words(chunk);
    end else begin : g_bytes
      assign chunk = pick_chunk(cur_addr, cur_rem, 1'b1);
      assign ctrl  = ctrl_bytes(chunk);
    end
  endgenerate

  assign nxt_addr = cur_addr + {15'b0, chunk};
  assign nxt_rem  = cur_rem  - {15'b0, chunk};

endmodule

// File: rtl/desc_holder.sv
module desc_holder #(
  parameter bit MARK_END = 1'b1,
  parameter int IDX_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [31:0]      push_addr,
  input  logic [31:0]      push_ctrl,
  input  logic             seal,
  output logic             desc_valid,
  output logic [IDX_W-1:0] desc_idx,
  output logic [31:0]      desc_addr,
  output logic [31:0]      desc_ctrl,
  output logic             held
);

  logic [31:0]      hold_addr_q, hold_ctrl_q;
  logic [IDX_W-1:0] next_idx_q;
  logic [31:0]      end_mask;

  generate
    if (MARK_END) begin : g_mark
      assign end_mask = 32'h8000_0000;
    end else begin : g_nomark
      assign end_mask = 32'h0000_0000;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held        <= 1'b0;
      hold_addr_q <= '0;
      hold_ctrl_q <= '0;
      next_idx_q  <= '0;
      desc_valid  <= 1'b0;
      desc_idx    <= '0;
      desc_addr   <= '0;
      desc_ctrl   <= '0;
    end else begin
      desc_valid <= 1'b0;
      if (clear) begin
        held       <= 1'b0;
        next_idx_q <= '0;
      end else if (push) begin
        if (held) begin
          desc_valid <= 1'b1;
          desc_idx   <= next_idx_q;
          desc_addr  <= hold_addr_q;
          desc_ctrl  <= hold_ctrl_q;
          next_idx_q <= next_idx_q + 1'b1;
        end
        held        <= 1'b1;
        hold_addr_q <= push_addr;
        hold_ctrl_q <= push_ctrl;
      end else if (seal && held) begin
        desc_valid <= 1'b1;
        desc_idx   <= next_idx_q;
        desc_addr  <= hold_addr_q;
        desc_ctrl  <= hold_ctrl_q | end_mask;
        next_idx_q <= next_idx_q + 1'b1;
        held       <= 1'b0;
      end
    end
  end

  // R11
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && $past(desc_valid) && !$past(clear)) |-> (desc_idx == $past(desc_idx) + 1'b1));

  // R2
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !MARK_END) || (desc_valid && MARK_END &&
      (({1'b0, desc_addr[15:0]} + {1'b0, desc_ctrl[15:0]}) <= 17'h10000)) || !desc_valid);

endmodule

// File: rtl/seg_desc_builder.sv
module seg_desc_builder
  import seg_desc_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  parameter bit ALT_FMT     = 1'b0,
  parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             seg_valid_i,
  input  logic [31:0]      seg_addr_i,
  input  logic [31:0]      seg_len_i,
  input  logic             seg_last_i,
  output logic             seg_ready_o,
  output logic             desc_valid_o,
  output logic [CNT_W-1:0] desc_idx_o,
  output logic [31:0]      desc_addr_o,
  output logic [31:0]      desc_ctrl_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] desc_total_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ENTRIES);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t           st_q;
  logic             busy_q, last_q;
  logic [31:0]      addr_q, rem_q;
  logic [CNT_W-1:0] cnt_q;

  logic [16:0] chunk;
  logic [31:0] ctrl_w, nxt_addr, nxt_rem;
  logic        at_limit, produce, overflow, seal, clear, holder_full;

  seg_chunker #(.ALT_FMT(ALT_FMT)) u_chunk (
    .cur_addr (addr_q),
    .cur_rem  (rem_q),
    .chunk    (chunk),
    .ctrl     (ctrl_w),
    .nxt_addr (nxt_addr),
    .nxt_rem  (nxt_rem)
  );

  assign at_limit    = (cnt_q == LIMIT);
  assign produce     = (st_q == S_RUN) && busy_q && !at_limit;
  assign overflow    = (st_q == S_RUN) && busy_q && at_limit;
  assign seal        = (st_q == S_FIN) && (cnt_q != '0);
  assign clear       = ((st_q == S_IDLE) && start_i) || overflow;
  assign seg_ready_o = (st_q == S_RUN) && !busy_q;

  desc_holder #(.MARK_END(!ALT_FMT), .IDX_W(CNT_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .push       (produce),
    .push_addr  (addr_q),
    .push_ctrl  (ctrl_w),
    .seal       (seal),
    .desc_valid (desc_valid_o),
    .desc_idx   (desc_idx_o),
    .desc_addr  (desc_addr_o),
    .desc_ctrl  (desc_ctrl_o),
    .held       (holder_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      busy_q       <= 1'b0;
      last_q       <= 1'b0;
      addr_q       <= '0;
      rem_q        <= '0;
      cnt_q        <= '0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
      desc_total_o <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q         <= S_RUN;
            cnt_q        <= '0;
            busy_q       <= 1'b0;
            desc_total_o <= '0;
          end
        end
        S_RUN: begin
          if (busy_q) begin
            if (at_limit) begin
              fail_o <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= S_IDLE;
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              addr_q <= nxt_addr;
              rem_q  <= nxt_rem;
              if (nxt_rem == '0) begin
                busy_q <= 1'b0;
                if (last_q) st_q <= S_FIN;
              end
            end
          end else if (seg_valid_i) begin
            if (seg_len_i == '0) begin
              if (seg_last_i) st_q <= S_FIN;
            end else begin
              addr_q <= seg_addr_i;
              rem_q  <= seg_len_i;
              last_q <= seg_last_i;
              busy_q <= 1'b1;
            end
          end
        end
        S_FIN: begin
          st_q <= S_IDLE;
          if (cnt_q == '0) fail_o <= 1'b1;
          else begin
            done_o       <= 1'b1;
            desc_total_o <= cnt_q;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R10
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R3
  chunk_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    produce |-> (chunk != '0) && ({15'b0, chunk} <= rem_q));

  // R4
  no_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && !ALT_FMT) |-> (desc_ctrl_o[15:0] != 16'h0000));

  // R5
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && !ALT_FMT && desc_ctrl_o[31]) |-> done_o);

  // R7
  empty_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o) |-> (desc_total_o != '0) && !holder_full);

endmodule

// File: tb/tb_seg_desc_builder.sv
`timescale 1ns/1ps
module tb_seg_desc_builder;

  localparam int MAXA = 256;
  localparam int MAXW = 8;
  localparam int CA = $clog2(MAXA + 1);
  localparam int CW = $clog2(MAXW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int sel = 0;
  logic st_d = 0, sv_d = 0, slast_d = 0;
  logic [31:0] sa_d = 0, sl_d = 0;

  logic rdy_a, dv_a, done_a, fail_a;
  logic [CA-1:0] idx_a, tot_a;
  logic [31:0] da_a, dc_a;
  logic rdy_w, dv_w, done_w, fail_w;
  logic [CW-1:0] idx_w, tot_w;
  logic [31:0] da_w, dc_w;

  seg_desc_builder #(.MAX_ENTRIES(MAXA), .ALT_FMT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(st_d && sel == 0), .seg_valid_i(sv_d && sel == 0),
    .seg_addr_i(sa_d), .seg_len_i(sl_d), .seg_last_i(slast_d), .seg_ready_o(rdy_a),
    .desc_valid_o(dv_a), .desc_idx_o(idx_a), .desc_addr_o(da_a), .desc_ctrl_o(dc_a),
    .done_o(done_a), .fail_o(fail_a), .desc_total_o(tot_a));

  seg_desc_builder #(.MAX_ENTRIES(MAXW), .ALT_FMT(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .start_i(st_d && sel == 1), .seg_valid_i(sv_d && sel == 1),
    .seg_addr_i(sa_d), .seg_len_i(sl_d), .seg_last_i(slast_d), .seg_ready_o(rdy_w),
    .desc_valid_o(dv_w), .desc_idx_o(idx_w), .desc_addr_o(da_w), .desc_ctrl_o(dc_w),
    .done_o(done_w), .fail_o(fail_w), .desc_total_o(tot_w));

  int total = 0, bad = 0;
  bit finished = 0;

  // segment list
  longint sg_a[0:31];
  longint sg_l[0:31];
  int ns = 0;

  // expected table
  logic [31:0] ea[0:511];
  logic [31:0] ec[0:511];
  int en = 0;
  bit efail = 0;

  // observed table
  logic [31:0] ma[0:511];
  logic [31:0] mc[0:511];
  int mi[0:511];
  int mn = 0;
  bit done_seen = 0, fail_seen = 0;
  int done_cnt = 0;
  int tot_seen = 0;

  always @(negedge clk) begin
    if (sel == 0) begin
      if (dv_a && mn < 512) begin ma[mn] = da_a; mc[mn] = dc_a; mi[mn] = int'(idx_a); mn++; end
      if (done_a) begin done_seen = 1; done_cnt++; tot_seen = int'(tot_a); end
      if (fail_a) fail_seen = 1;
    end else begin
      if (dv_w && mn < 512) begin ma[mn] = da_w; mc[mn] = dc_w; mi[mn] = int'(idx_w); mn++; end
      if (done_w) begin done_seen = 1; done_cnt++; tot_seen = int'(tot_w); end
      if (fail_w) fail_seen = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add_seg(input longint a, input longint l);
    sg_a[ns] = a; sg_l[ns] = l; ns++;
  endtask

  // reference model, written from the requirements
  task automatic model(input bit alt, input int maxe);
    en = 0; efail = 0;
    for (int s = 0; s < ns; s++) begin
      longint a = sg_a[s];
      longint l = sg_l[s];
      while (l > 0) begin
        longint room = 65536 - (a % 65536);
        longint c = (l < room) ? l : room;
        if (!alt && c == 65536) begin
          ea[en] = 32'(a);         ec[en] = 32'h8000; en++;
          ea[en] = 32'(a + 32768); ec[en] = 32'h8000; en++;
        end else if (alt) begin
          ea[en] = 32'(a); ec[en] = 32'((c / 4 - 1) * 65536); en++;
        end else begin
          ea[en] = 32'(a); ec[en] = 32'(c); en++;
        end
        a += c; l -= c;
        if (en > 500) l = 0;
      end
    end
    if (en > maxe || en == 0) efail = 1;
    else if (!alt) ec[en-1] = ec[en-1] | 32'h8000_0000;
  endtask

  task automatic run_build(input int which);
    sel = which;
    mn = 0; done_seen = 0; fail_seen = 0; done_cnt = 0; tot_seen = -1;
    @(negedge clk); st_d = 1;
    @(negedge clk); st_d = 0;
    for (int s = 0; s < ns; s++) begin
      sv_d = 1; sa_d = 32'(sg_a[s]); sl_d = 32'(sg_l[s]); slast_d = (s == ns - 1);
      for (int g = 0; g < 3000 && !(which == 0 ? rdy_a : rdy_w) && !fail_seen; g++) @(negedge clk);
      if (fail_seen) break;
      @(posedge clk);
      @(negedge clk);
      sv_d = 0;
    end
    sv_d = 0; slast_d = 0;
    for (int g = 0; g < 3000 && !done_seen && !fail_seen; g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req, input bit alt, input int maxe);
    model(alt, maxe);
    if (efail) begin
      chk(fail_seen && !done_seen, req, "fail status", {fail_seen, done_seen}, 2'b10);
      chk(mn <= maxe, req, "emitted within limit", mn, maxe);
    end else begin
      int errs = 0;
      int first = -1;
      chk(done_seen && !fail_seen && done_cnt == 1, req, "done once, no fail",
          {done_cnt[3:0], fail_seen}, 5'b00010);
      chk(tot_seen == en, req, "descriptor total", tot_seen, en);
      chk(mn == en, req, "descriptor count seen", mn, en);
      for (int k = 0; k < en && k < mn; k++)
        if (ma[k] !== ea[k] || mc[k] !== ec[k] || mi[k] != k) begin
          errs++; if (first < 0) first = k;
        end
      if (first < 0) chk(1'b1, req, "table", 0, 0);
      else chk(1'b0, req, $sformatf("table entry %0d (addr/ctrl)", first),
               {ma[first], mc[first]}, {ea[first], ec[first]});
    end
  endtask

  // R1
  task automatic t_reset();
    chk(rdy_a == 0 && rdy_w == 0, "R1", "ready after reset", {rdy_a, rdy_w}, 0);
    chk(dv_a == 0 && dv_w == 0, "R1", "desc_valid after reset", {dv_a, dv_w}, 0);
    chk(done_a == 0 && done_w == 0, "R1", "done after reset", {done_a, done_w}, 0);
    chk(fail_a == 0 && fail_w == 0, "R1", "fail after reset", {fail_a, fail_w}, 0);
  endtask

  // R5 R10 R11: one short aligned segment
  task automatic t_single();
    ns = 0; add_seg(64'h1000, 64'h200);
    run_build(0); compare("R5", 0, MAXA);
  endtask

  // R2 R3: straddles a 64 KB boundary
  task automatic t_cross();
    ns = 0; add_seg(64'h1_FF00, 64'h300);
    run_build(0); compare("R2", 0, MAXA);
    ns = 0; add_seg(64'h2_4000, 64'h2_2000);
    run_build(0); compare("R3", 0, MAXA);
  endtask

  // R4: aligned full 64 KB window
  task automatic t_full64();
    ns = 0; add_seg(64'h3_0000, 64'h1_0000);
    run_build(0); compare("R4", 0, MAXA);
  endtask

  // R8 R11: mixed list with zero-length entries
  task automatic t_mixed();
    ns = 0;
    add_seg(64'h8000_0100, 64'h40);
    add_seg(64'h1234_0000, 0);
    add_seg(64'h0005_F000, 64'h1_1000);
    add_seg(64'h9000_0000, 64'h80);
    add_seg(64'h0, 0);
    run_build(0); compare("R8", 0, MAXA);
  endtask

  // R7: nothing to transfer
  task automatic t_empty();
    ns = 0; add_seg(64'h100, 0); add_seg(64'h200, 0);
    run_build(0); compare("R7", 0, MAXA);
  endtask

  // R6: exactly at the limit, then one split past it
  task automatic t_limit();
    ns = 0; add_seg(64'h100_0000, 64'h80_0000);
    run_build(0); compare("R6", 0, MAXA);
    ns = 0; add_seg(64'h100_0000, 64'h81_0000);
    run_build(0); compare("R6", 0, MAXA);
  endtask

  // R9: word-count format
  task automatic t_alt();
    ns = 0; add_seg(64'h1_FFF0, 64'h20); add_seg(64'h4_0000, 64'h1_0000);
    run_build(1); compare("R9", 1, MAXW);
    ns = 0; add_seg(64'h0, 64'h9_0000);
    run_build(1); compare("R9", 1, MAXW);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_single();
    t_cross();
    t_full64();
    t_mixed();
    t_empty();
    t_limit();
    t_alt();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule